// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller with Timed Refresh

This block is a synchronous controller for a 1M x 16 asynchronous DRAM that supports extended-data-out page accesses. A host issues single-word reads and writes through a valid/ready port. Each request carries a 20-bit word address, two byte enables and write data. The controller splits the address into a 10-bit row and a 10-bit column and drives them in turn on a shared address bus. It also drives the active-low row strobe, the upper and lower column strobes, the write enable and the output enable.

After an access the row stays open. A later request to the same row needs only a column cycle. A request to a different row first precharges, then activates the new row. An open row is closed before the row strobe reaches its maximum low time.

A free-running timer raises a refresh request at a fixed interval. A pending refresh takes priority over host traffic. The controller closes any open row, waits out the precharge and then runs a column-before-row refresh cycle. Every strobe duration is a whole number of clock cycles set by a parameter.

Top module: `edo_dram_ctrl`

## Requirements
- R1: The row address is bits 19:10 of the word address and appears on `dram_addr` while the row strobe falls. The column address is bits 9:0 and appears on `dram_addr` while a column strobe falls.
- R2: While a row is open, a request to that same row runs a column cycle without a new row-strobe falling edge.
- R3: A request to a row other than the open one first raises the row strobe for precharge, then activates the new row, then runs the column cycle.
- R4: Refreshes start at least once every `REF_PERIOD` cycles, plus a bounded wait of `T_RCD+T_CAS+T_RP+T_RFR+8` cycles for the operation in progress.
- R5: In a refresh, both column strobes are low in the cycle before the row strobe falls. No row address is needed.
- R6: The row strobe never stays low for more than `T_RAS_MAX` consecutive cycles.
- R7: The row strobe stays high for at least `T_RP` cycles before it falls. A column strobe falls no earlier than `T_RCD` cycles after the row strobe falls.
- R8: `dram_ucas_n` strobes data bits 15:8 and `dram_lcas_n` strobes bits 7:0, selected by `req_be[1]` and `req_be[0]`. A write changes only the enabled bytes.
- R9: Read data is sampled at the last column-strobe cycle. It is returned with a one-cycle `rsp_valid` pulse, and bytes that were not enabled read as zero.
- R10: `req_ready` is low while a refresh is pending or running and while a row change is in progress. It is high after reset, and it is never high while a column strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address {row, column} |
| req_be | input | 2 | Byte enables {upper, lower} |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled bytes zero |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data to the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
The strobes are decoded from the state register, so they change one edge after the decision that causes them. The bench's DRAM model watches the pins at each falling clock edge and therefore sees every strobe edge half a cycle after it happens.

A request is taken at the rising edge where valid and ready are both high. After a page hit, the column strobe falls in the next cycle. After a miss it falls `T_RP+T_RCD` cycles later. Read data appears with `rsp_valid` one cycle after the last of the `T_CAS` strobe cycles.

The host tasks never assume a fixed latency. They poll `req_ready` and `rsp_valid` at falling edges, and refresh or row-limit closures only stretch the wait. The checks on timing and counts are made on records kept by the model.

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int ROW_W      = 10,
  parameter int COL_W      = 10,
  parameter int DATA_W     = 16,
  parameter int T_RCD      = 2,
  parameter int T_CAS      = 2,
  parameter int T_RP       = 3,
  parameter int T_RFR      = 4,
  parameter int T_RAS_MAX  = 500,
  parameter int REF_PERIOD = 780
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ROW_W+COL_W-1:0]  req_addr,
  input  logic [1:0]              req_be,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
  output logic                    dram_ras_n,
  output logic                    dram_ucas_n,
  output logic                    dram_lcas_n,
  output logic                    dram_we_n,
  output logic                    dram_oe_n,
  output logic [DATA_W-1:0]       dram_dq_out,
  output logic                    dram_dq_oe,
  input  logic [DATA_W-1:0]       dram_dq_in
);
  localparam int AW      = ROW_W + COL_W;
  localparam int BW      = DATA_W / 2;
  localparam int MW      = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int CW      = $clog2(T_RP + T_RCD + T_CAS + T_RFR + 2);
  localparam int RW      = $clog2(T_RAS_MAX + 2);
  localparam int FW      = $clog2(REF_PERIOD + 1);
  localparam int RAS_LIM = T_RAS_MAX - T_CAS - 2;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ACT, S_CAS, S_RFC, S_RFR} st_t;

  st_t               st, after;
  logic [CW-1:0]     cnt, cur_len;
  logic              row_open, ref_pend;
  logic [ROW_W-1:0]  open_row, a_row;
  logic [COL_W-1:0]  a_col;
  logic              a_we;
  logic [1:0]        a_be;
  logic [DATA_W-1:0] a_wd;
  logic [RW-1:0]     ras_cnt;
  logic [FW-1:0]     ref_tmr;

  wire ras_low  = (st == S_ACT) || (st == S_CAS) || (st == S_RFR) || (st == S_IDLE && row_open);
  wire refcas   = (st == S_RFC) || (st == S_RFR);
  wire close_now = row_open && (ras_cnt >= RW'(RAS_LIM));
  wire hit      = row_open && (req_addr[AW-1:COL_W] == open_row);
  wire last     = (cnt == cur_len - CW'(1));

  always_comb begin
    case (st)
      S_PRE:   cur_len = CW'(T_RP);
      S_ACT:   cur_len = CW'(T_RCD);
      S_CAS:   cur_len = CW'(T_CAS);
      S_RFR:   cur_len = CW'(T_RFR);
      default: cur_len = CW'(1);
    endcase
  end

  assign req_ready   = (st == S_IDLE) && !ref_pend && !close_now;
  assign dram_ras_n  = !ras_low;
  assign dram_ucas_n = !((st == S_CAS && a_be[1]) || refcas);
  assign dram_lcas_n = !((st == S_CAS && a_be[0]) || refcas);
  assign dram_we_n   = !(st == S_CAS && a_we);
  assign dram_oe_n   = !(st == S_CAS && !a_we);
  assign dram_addr   = (st == S_ACT) ? MW'(a_row) : MW'(a_col);
  assign dram_dq_out = a_wd;
  assign dram_dq_oe  = (st == S_CAS) && a_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      after     <= S_IDLE;
      cnt       <= '0;
      row_open  <= 1'b0;
      open_row  <= '0;
      a_row     <= '0;
      a_col     <= '0;
      a_we      <= 1'b0;
      a_be      <= '0;
      a_wd      <= '0;
      ras_cnt   <= '0;
      ref_tmr   <= '0;
      ref_pend  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      ras_cnt   <= ras_low ? ras_cnt + RW'(1) : '0;
      cnt       <= last ? '0 : cnt + CW'(1);
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (ref_pend) begin
            if (row_open) begin st <= S_PRE; after <= S_RFC; end
            else st <= S_RFC;
          end else if (close_now) begin
            st <= S_PRE; after <= S_IDLE;
          end else if (req_valid) begin
            a_row <= req_addr[AW-1:COL_W];
            a_col <= req_addr[COL_W-1:0];
            a_we  <= req_write;
            a_be  <= req_be;
            a_wd  <= req_wdata;
            if (hit) st <= S_CAS;
            else if (row_open) begin st <= S_PRE; after <= S_ACT; end
            else st <= S_ACT;
          end
        end
        S_PRE: begin
          row_open <= 1'b0;
          if (last) st <= after;
        end
        S_ACT: if (last) begin
          st       <= S_CAS;
          row_open <= 1'b1;
          open_row <= a_row;
        end
        S_CAS: if (last) begin
          st <= S_IDLE;
          if (!a_we) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= {dram_dq_in[DATA_W-1:BW] & {BW{a_be[1]}},
                          dram_dq_in[BW-1:0]      & {BW{a_be[0]}}};
          end
        end
        S_RFC: if (last) st <= S_RFR;
        S_RFR: if (last) begin
          st       <= S_PRE;
          after    <= S_IDLE;
          ref_pend <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
      if (ref_tmr == FW'(REF_PERIOD - 1)) begin
        ref_tmr  <= '0;
        ref_pend <= 1'b1;
      end else begin
        ref_tmr <= ref_tmr + FW'(1);
      end
    end
  end
endmodule

module edo_dram_chk #(
  parameter int T_RCD      = 2,
  parameter int T_CAS      = 2,
  parameter int T_RP       = 3,
  parameter int T_RFR      = 4,
  parameter int T_RAS_MAX  = 500,
  parameter int REF_PERIOD = 780
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic ucas_n,
  input logic lcas_n,
  input logic req_ready
);
  localparam int SLACK = T_RCD + T_CAS + T_RP + T_RFR + 8;
  int lo_cnt, hi_cnt, gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= 0;
      hi_cnt <= T_RP;
      gap    <= 0;
    end else begin
      lo_cnt <= ras_n ? 0 : lo_cnt + 1;
      hi_cnt <= !ras_n ? 0 : ((hi_cnt < T_RP) ? hi_cnt + 1 : hi_cnt);
      gap    <= ($fell(ras_n) && !ucas_n && !lcas_n) ? 0 : gap + 1;
    end
  end

  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && (!ucas_n || !lcas_n)) |-> ($past(!ucas_n) && $past(!lcas_n))); // R5
  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (lo_cnt < T_RAS_MAX)); // R6
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= T_RP)); // R7
  AST_RAS_TO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(ucas_n) || $fell(lcas_n)) && !ras_n) |-> (lo_cnt >= T_RCD)); // R7
  AST_REF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= REF_PERIOD + SLACK); // R4
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ucas_n && lcas_n)); // R10
endmodule

bind edo_dram_ctrl edo_dram_chk #(
  .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RFR(T_RFR),
  .T_RAS_MAX(T_RAS_MAX), .REF_PERIOD(REF_PERIOD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .ucas_n(dram_ucas_n),
  .lcas_n(dram_lcas_n), .req_ready(req_ready)
);

// File: tb/sim_edo_dram_ctrl.sv
module sim_edo_dram_ctrl;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, T_RFR = 4;
  localparam int T_RAS_MAX = 40, REF_PERIOD = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [9:0]  dram_addr;
  logic dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [15:0] dram_dq_out;
  logic [15:0] dram_dq_in = '0;

  always #10 clk = ~clk;

  edo_dram_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RFR(T_RFR),
                  .T_RAS_MAX(T_RAS_MAX), .REF_PERIOD(REF_PERIOD)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n),
    .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  int n_chk = 0, n_bad = 0, cyc = 0;

  // DRAM model, evaluated at falling clock edges
  logic [15:0] mem [logic [19:0]];
  logic [9:0] cur_row = '0;
  logic p_ras = 1'b1, p_u = 1'b1, p_l = 1'b1;
  int ref_cnt = 0, act_cnt = 0, cbr_bad = 0, pre_bad = 0, busy_bad = 0;
  int hi_run = 100, lo_run = 0, max_lo = 0;

  function automatic logic [15:0] rd_mem(logic [19:0] k);
    return mem.exists(k) ? mem[k] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !dram_ras_n) begin
        if (!dram_ucas_n && !dram_lcas_n) begin
          ref_cnt++;
          if (p_u || p_l) cbr_bad++;
        end else begin
          cur_row = dram_addr;
          act_cnt++;
        end
        if (hi_run < T_RP) pre_bad++;
      end
      if (!dram_ras_n && ((p_u && !dram_ucas_n) || (p_l && !dram_lcas_n))) begin
        if (!dram_we_n) begin
          logic [15:0] w;
          w = rd_mem({cur_row, dram_addr});
          if (!dram_ucas_n) w[15:8] = dram_dq_out[15:8];
          if (!dram_lcas_n) w[7:0]  = dram_dq_out[7:0];
          mem[{cur_row, dram_addr}] = w;
        end else begin
          dram_dq_in <= rd_mem({cur_row, dram_addr});
        end
      end
      if (req_ready && (!dram_ucas_n || !dram_lcas_n || (!dram_ras_n && refcyc()))) busy_bad++;
      hi_run = dram_ras_n ? hi_run + 1 : 0;
      lo_run = dram_ras_n ? 0 : lo_run + 1;
      if (lo_run > max_lo) max_lo = lo_run;
      p_ras = dram_ras_n; p_u = dram_ucas_n; p_l = dram_lcas_n;
    end
  end

  function automatic bit refcyc();
    return !dram_ucas_n && !dram_lcas_n && dram_we_n && dram_oe_n;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host(bit wr, logic [19:0] a, logic [1:0] be, logic [15:0] wd,
                      output logic [15:0] rd);
    rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr) begin
      while (!rsp_valid) @(negedge clk);
      rd = rsp_rdata;
    end
    while (!req_ready) @(negedge clk);
  endtask

  task automatic wait_ref();
    int r;
    r = ref_cnt;
    while (ref_cnt == r) @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(dram_ras_n && dram_ucas_n && dram_lcas_n, "R10 reset strobes",
          {dram_ras_n, dram_ucas_n, dram_lcas_n}, 3'b111);
    check(req_ready, "R10 ready after reset", req_ready, 1);
    check(!rsp_valid, "R9 no response at reset", rsp_valid, 0);
  endtask

  task automatic t_word();
    logic [15:0] rd;
    wait_ref();
    host(1'b1, 20'h12345, 2'b11, 16'hA5C3, rd);
    host(1'b0, 20'h12345, 2'b11, 16'h0, rd);
    check(rd == 16'hA5C3, "R9 word readback", rd, 16'hA5C3);
    check(rd_mem({10'h048, 10'h345}) == 16'hA5C3, "R1 row/col split",
          rd_mem({10'h048, 10'h345}), 16'hA5C3);
  endtask

  task automatic t_bytes();
    logic [15:0] rd;
    wait_ref();
    host(1'b1, 20'h0ABCD, 2'b11, 16'h1111, rd);
    host(1'b1, 20'h0ABCD, 2'b10, 16'hAB22, rd);
    host(1'b0, 20'h0ABCD, 2'b11, 16'h0, rd);
    check(rd == 16'hAB11, "R8 upper byte write", rd, 16'hAB11);
    host(1'b1, 20'h0ABCD, 2'b01, 16'h33CD, rd);
    host(1'b0, 20'h0ABCD, 2'b11, 16'h0, rd);
    check(rd == 16'hABCD, "R8 lower byte write", rd, 16'hABCD);
    host(1'b0, 20'h0ABCD, 2'b01, 16'h0, rd);
    check(rd == 16'h00CD, "R9 upper masked", rd, 16'h00CD);
    host(1'b0, 20'h0ABCD, 2'b10, 16'h0, rd);
    check(rd == 16'hAB00, "R9 lower masked", rd, 16'hAB00);
  endtask

  task automatic t_hit();
    logic [15:0] rd;
    int a0;
    wait_ref();
    host(1'b1, {10'h155, 10'h001}, 2'b11, 16'h0101, rd);
    a0 = act_cnt;
    host(1'b1, {10'h155, 10'h002}, 2'b11, 16'h0202, rd);
    host(1'b0, {10'h155, 10'h001}, 2'b11, 16'h0, rd);
    check(act_cnt == a0, "R2 page hit keeps row", act_cnt, a0);
    check(rd == 16'h0101, "R2 page hit data", rd, 16'h0101);
  endtask

  task automatic t_miss();
    logic [15:0] rd;
    int a0;
    wait_ref();
    host(1'b1, {10'h2AA, 10'h010}, 2'b11, 16'h5A5A, rd);
    a0 = act_cnt;
    host(1'b1, {10'h0F0, 10'h010}, 2'b11, 16'hC3C3, rd);
    check(act_cnt == a0 + 1, "R3 row miss activates", act_cnt, a0 + 1);
    host(1'b0, {10'h2AA, 10'h010}, 2'b11, 16'h0, rd);
    check(rd == 16'h5A5A, "R3 row miss data", rd, 16'h5A5A);
    check(pre_bad == 0, "R7 precharge gap", pre_bad, 0);
  endtask

  task automatic t_refresh();
    int r0;
    r0 = ref_cnt;
    repeat (3 * REF_PERIOD) @(negedge clk);
    check(ref_cnt - r0 >= 2 && ref_cnt - r0 <= 4, "R4 refresh rate", ref_cnt - r0, 3);
    check(cbr_bad == 0, "R5 cas before ras", cbr_bad, 0);
    check(busy_bad == 0, "R10 ready held off", busy_bad, 0);
  endtask

  task automatic t_rasmax();
    logic [15:0] rd;
    for (int i = 0; i < 24; i++)
      host(1'b1, {10'h3C3, 10'(i)}, 2'b11, 16'(i * 3 + 7), rd);
    host(1'b0, {10'h3C3, 10'd17}, 2'b11, 16'h0, rd);
    check(rd == 16'd58, "R6 data across row reopen", rd, 58);
    check(max_lo <= T_RAS_MAX, "R6 ras width", max_lo, T_RAS_MAX);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      summary();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_word();
    t_bytes();
    t_hit();
    t_miss();
    t_refresh();
    t_rasmax();
    summary();
  end
endmodule